// File: doc/BRIEF.md
# Trellis Min-Max Check-Node Processor

This block is the check-node core of a non-binary LDPC decoder over GF(16). It receives one parity-check row at a time, one column per cycle. Each column is a vector of sixteen unsigned reliabilities, one for each field symbol, where a smaller value means a more reliable symbol. For each column the block takes the best symbol as that column's hard decision. It then re-indexes the vector so that the hard decision lands at index 0, with the entry for symbol `a` moved to index `a XOR z`.

Across the columns of the row, the block keeps, for every delta-domain symbol, the best value, the runner-up and the column that supplied the best. After the row's last column it builds an extra trellis column. For each non-zero symbol, this value is the cheapest way to reach that symbol by moving one column, or two columns whose deviations XOR to it. The cost of a configuration is the worst best-value it uses.

The block emits a compressed message set, not a full vector per edge. It carries the best and runner-up tables, the winner columns, the extra column, the XOR of all hard decisions and the list of hard decisions. A variable-node stage rebuilds the per-edge messages from that set.

Top module: `tmm_check_node`

## Requirements
- R1: The hard decision of a column is the symbol holding the smallest reliability, with the lowest symbol chosen on ties. Column n's decision is reported in `out_z[n*4 +: 4]`.
- R2: The delta-domain value of a column at index `a XOR z` equals its input reliability at symbol `a`, so index 0 always holds the column's smallest value.
- R3: `out_m1[a*W +: W]` is the smallest delta value at index `a` over all columns of the row. `out_idx[a*IDXW +: IDXW]` is the column that supplied it, counted from 0 in arrival order, with the lowest column chosen on ties.
- R4: `out_m2[a*W +: W]` is the second smallest delta value at index `a` over the columns. When two columns tie for the best value, it equals `out_m1` at that index.
- R5: For every a in 1..15, `out_dq[a*W +: W]` is the minimum of `m1(a)` and of `max(m1(b), m1(b XOR a))` over all non-zero b ≠ a. `out_dq[0 +: W]` is 0.
- R6: `out_syn` is the XOR of the hard decisions of all columns of the row.
- R7: `out_valid` is high for exactly one cycle. That cycle follows the clock edge after the edge that accepted the column marked `in_last`. All outputs hold their values until the next row's results replace them.
- R8: A cycle with `in_valid` low accepts no column: neither its `in_vec` nor its `in_last` changes any result.
- R9: A new row may start in the cycle right after the previous row's last column, and both rows produce correct results.
- R10: After reset, `out_valid` is low and every output field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Column present on `in_vec` this cycle |
| in_last | input | 1 | Marks the row's final column (column DC-1) |
| in_vec | input | Q*W | Reliability of symbol a in bits `[a*W +: W]` |
| out_valid | output | 1 | One-cycle strobe for a finished row |
| out_m1 | output | Q*W | Best delta value per symbol |
| out_m2 | output | Q*W | Second-best delta value per symbol |
| out_idx | output | Q*IDXW | Column that gave the best value per symbol |
| out_dq | output | Q*W | Extra-column value per symbol (slot 0 is zero) |
| out_syn | output | P | XOR of all hard decisions |
| out_z | output | DC*P | Hard decision of each column |

## Verification
Some properties are checked by assertions on every cycle:
- index 0 of each delta vector is never worse than any other index;
- the best value never exceeds the runner-up, and the winner column stays within the degree;
- each extra-column value never exceeds its one-deviation cost;
- the valid strobe lasts a single cycle and follows the row's last column by exactly two edges;
- idle cycles leave the column count unchanged.

Other behaviour can only be shown by the bench's scenarios. The exact minima and runner-ups, the tie rules, the two-deviation search, the decision XOR and the isolation of junk data between columns need exact values. So do back-to-back rows. The bench computes those values from its own model of a row.

// File: rtl/tmm_pkg.sv
// Package: shared types of the trellis min-max check-node processor.
// Assumes nothing beyond standard SystemVerilog.
package tmm_pkg;

    // Update chosen for one trellis row when a new column arrives
    typedef enum logic [1:0] {
        ACT_INIT   = 2'd0,   // first column of the row: load it
        ACT_BEST   = 2'd1,   // new strict best: old best becomes runner-up
        ACT_SECOND = 2'd2,   // beats only the runner-up
        ACT_KEEP   = 2'd3    // no change
    } sort_act_t;

endpackage

// File: rtl/tmm_hd.sv
// Module: tmm_hd
// Finds a column's hard-decision symbol (smallest reliability, lowest
// symbol on ties) and re-indexes the vector into the delta domain so that
// delta[a ^ z] = vec[a]. Purely combinational.
// Assumes: entry a of the vector sits at bits [a*W +: W].
module tmm_hd #(
    parameter int P = 4,
    parameter int W = 6,
    localparam int Q = 1 << P
) (
    input  logic [Q*W-1:0] vec,
    output logic [P-1:0]   z,
    output logic [Q*W-1:0] delta
);

    // Scan for the strict minimum; an earlier symbol keeps ties
    always_comb begin
        logic [W-1:0] best;
        best = vec[0 +: W];
        z    = '0;
        for (int a = 1; a < Q; a++) begin
            if (vec[a*W +: W] < best) begin
                best = vec[a*W +: W];
                z    = a[P-1:0];
            end
        end
    end

    // Shift the vector: index a of the delta vector reads symbol a ^ z
    always_comb begin
        for (int a = 0; a < Q; a++) begin
            delta[a*W +: W] = vec[(a ^ int'(z))*W +: W];
        end
    end

endmodule

// File: rtl/tmm_sort.sv
// Module: tmm_sort
// Tracks, for each delta-domain row, the best value, the runner-up and
// the column that gave the best, over the columns of one check row.
// Assumes: 'first' is high with the row's first column.
// A later column replaces the best only when strictly smaller.
module tmm_sort #(
    parameter int P    = 4,
    parameter int W    = 6,
    parameter int DC   = 6,
    parameter int IDXW = 3,
    localparam int Q   = 1 << P
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              first,
    input  logic [IDXW-1:0]   col,
    input  logic [Q*W-1:0]    delta,
    output logic [Q*W-1:0]    m1,
    output logic [Q*W-1:0]    m2,
    output logic [Q*IDXW-1:0] idx
);
    import tmm_pkg::*;

    for (genvar r = 0; r < Q; r++) begin : g_row
        sort_act_t    act;
        logic [W-1:0] d;

        assign d = delta[r*W +: W];

        // Decide how this row's pair of best values changes
        always_comb begin
            if (first)                  act = ACT_INIT;
            else if (d < m1[r*W +: W])  act = ACT_BEST;
            else if (d < m2[r*W +: W])  act = ACT_SECOND;
            else                        act = ACT_KEEP;
        end

        // Apply the chosen update on each accepted column
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m1[r*W +: W]          <= '0;
                m2[r*W +: W]          <= '0;
                idx[r*IDXW +: IDXW]   <= '0;
            end else if (upd) begin
                case (act)
                    ACT_INIT: begin
                        m1[r*W +: W]        <= d;
                        m2[r*W +: W]        <= '1;
                        idx[r*IDXW +: IDXW] <= col;
                    end
                    ACT_BEST: begin
                        m2[r*W +: W]        <= m1[r*W +: W];
                        m1[r*W +: W]        <= d;
                        idx[r*IDXW +: IDXW] <= col;
                    end
                    ACT_SECOND: m2[r*W +: W] <= d;
                    default: ;
                endcase
            end
        end

        AST_BEST_NOT_WORSE: assert property (@(posedge clk) disable iff (!rst_n)
            m1[r*W +: W] <= m2[r*W +: W]);  // R4
        AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            int'(idx[r*IDXW +: IDXW]) < DC);  // R3
    end

endmodule

// File: rtl/tmm_extra.sv
// Module: tmm_extra
// Builds the extra trellis column. For each non-zero symbol a it takes the
// minimum of the one-deviation cost m1(a) and every two-deviation cost
// max(m1(b), m1(b^a)) with b non-zero and b != a. Purely combinational.
// Assumes: m1 carries rows 1..Q-1 only, row r at bits [(r-1)*W +: W].
module tmm_extra #(
    parameter int P = 4,
    parameter int W = 6,
    localparam int Q = 1 << P
) (
    input  logic [(Q-1)*W-1:0] m1,
    output logic [Q*W-1:0]     dq
);

    // Min over configurations of the max of the best values used
    always_comb begin
        logic [W-1:0] best;
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] t;
        dq = '0;
        for (int a = 1; a < Q; a++) begin
            best = m1[(a-1)*W +: W];
            for (int b = 1; b < Q; b++) begin
                if (b != a) begin
                    x = m1[(b-1)*W +: W];
                    y = m1[((b ^ a)-1)*W +: W];
                    t = (x > y) ? x : y;
                    if (t < best) best = t;
                end
            end
            dq[a*W +: W] = best;
        end
    end

endmodule

// File: rtl/tmm_check_node.sv
// Module: tmm_check_node
// Trellis min-max check-node processor over GF(2^P). Accepts one column
// vector per cycle, builds per-symbol best/runner-up tables in the delta
// domain and, after the last column, emits the compressed message set with
// the extra column, the decision XOR and the decision list.
// Assumes: each row has exactly DC columns; in_last marks column DC-1.
module tmm_check_node #(
    parameter int P    = 4,
    parameter int W    = 6,
    parameter int DC   = 6,
    localparam int Q    = 1 << P,
    localparam int IDXW = (DC > 1) ? $clog2(DC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [Q*W-1:0]    in_vec,
    output logic              out_valid,
    output logic [Q*W-1:0]    out_m1,
    output logic [Q*W-1:0]    out_m2,
    output logic [Q*IDXW-1:0] out_idx,
    output logic [Q*W-1:0]    out_dq,
    output logic [P-1:0]      out_syn,
    output logic [DC*P-1:0]   out_z
);

    logic [P-1:0]      hd_z;
    logic [Q*W-1:0]    hd_delta;
    logic [IDXW-1:0]   col_q;
    logic              first_col;
    logic [Q*W-1:0]    srt_m1;
    logic [Q*W-1:0]    srt_m2;
    logic [Q*IDXW-1:0] srt_idx;
    logic [Q*W-1:0]    ext_dq;
    logic [DC*P-1:0]   z_q;
    logic [P-1:0]      syn_q;
    logic              emit_q;

    assign first_col = (col_q == '0);

    tmm_hd #(.P(P), .W(W)) u_hd (
        .vec   (in_vec),
        .z     (hd_z),
        .delta (hd_delta)
    );

    tmm_sort #(.P(P), .W(W), .DC(DC), .IDXW(IDXW)) u_sort (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (in_valid),
        .first (first_col),
        .col   (col_q),
        .delta (hd_delta),
        .m1    (srt_m1),
        .m2    (srt_m2),
        .idx   (srt_idx)
    );

    tmm_extra #(.P(P), .W(W)) u_extra (
        .m1 (srt_m1[Q*W-1:W]),
        .dq (ext_dq)
    );

    // Column position within the row; wraps to zero after the last column
    always_ff @(posedge clk) begin
        if (!rst_n)        col_q <= '0;
        else if (in_valid) col_q <= in_last ? '0 : col_q + 1'b1;
    end

    // Record each column's decision and accumulate their XOR
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q   <= '0;
            syn_q <= '0;
        end else if (in_valid) begin
            z_q[col_q*P +: P] <= hd_z;
            syn_q             <= first_col ? hd_z : (syn_q ^ hd_z);
        end
    end

    // Flag that the tables hold a finished row for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) emit_q <= 1'b0;
        else        emit_q <= in_valid && in_last;
    end

    // Capture the compressed message set and pulse out_valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_m1    <= '0;
            out_m2    <= '0;
            out_idx   <= '0;
            out_dq    <= '0;
            out_syn   <= '0;
            out_z     <= '0;
        end else begin
            out_valid <= emit_q;
            if (emit_q) begin
                out_m1  <= srt_m1;
                out_m2  <= srt_m2;
                out_idx <= srt_idx;
                out_dq  <= ext_dq;
                out_syn <= syn_q;
                out_z   <= z_q;
            end
        end
    end

    AST_LAST_AT_DEGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |-> (col_q == IDXW'(DC - 1)));  // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);  // R7
    AST_EMIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> ##1 out_valid);  // R7
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(col_q));  // R8

    for (genvar a = 1; a < Q; a++) begin : g_chk
        AST_ROW0_BEST: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (hd_delta[0 +: W] <= hd_delta[a*W +: W]));  // R2
        AST_DQ_ONE_DEV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_dq[a*W +: W] <= out_m1[a*W +: W]));  // R5
    end

endmodule

// File: tb/tb_tmm_check_node.sv
// Bench for tmm_check_node: a behavioural model of each row (arrays,
// integers, a queue of expected results) compared on every clock.
module tb_tmm_check_node;

    localparam int P    = 4;
    localparam int Q    = 16;
    localparam int W    = 6;
    localparam int DC   = 6;
    localparam int IDXW = 3;

    typedef struct {
        logic [Q*W-1:0]    m1;
        logic [Q*W-1:0]    m2;
        logic [Q*W-1:0]    dq;
        logic [Q*IDXW-1:0] idx;
        logic [P-1:0]      syn;
        logic [DC*P-1:0]   z;
        int                due;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_last = 1'b0;
    logic [Q*W-1:0]    in_vec = '0;
    logic              out_valid;
    logic [Q*W-1:0]    out_m1;
    logic [Q*W-1:0]    out_m2;
    logic [Q*IDXW-1:0] out_idx;
    logic [Q*W-1:0]    out_dq;
    logic [P-1:0]      out_syn;
    logic [DC*P-1:0]   out_z;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   ncyc     = 0;
    bit   finished = 0;
    exp_t expq[$];

    int   fz[DC];
    int   fd[DC][Q];
    int   fcol = 0;
    int   vals[Q];

    always #2 clk = ~clk;   // 250 MHz

    tmm_check_node #(.P(P), .W(W), .DC(DC)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_vec(in_vec), .out_valid(out_valid), .out_m1(out_m1),
        .out_m2(out_m2), .out_idx(out_idx), .out_dq(out_dq),
        .out_syn(out_syn), .out_z(out_z)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare outputs against the model once per cycle
    task automatic compare();
        bit   due_now;
        exp_t e;
        due_now = (expq.size() > 0) && (expq[0].due == ncyc);
        chk(out_valid == due_now, "R7 out_valid", 128'(out_valid), 128'(due_now));
        if (due_now) begin
            e = expq.pop_front();
            chk(out_m1 == e.m1, "R2/R3 best table", 128'(out_m1), 128'(e.m1));
            chk(out_idx == e.idx, "R3 winner columns", 128'(out_idx), 128'(e.idx));
            chk(out_m2 == e.m2, "R4 runner-up table", 128'(out_m2), 128'(e.m2));
            chk(out_dq == e.dq, "R5 extra column", 128'(out_dq), 128'(e.dq));
            chk(out_syn == e.syn, "R6 decision XOR", 128'(out_syn), 128'(e.syn));
            chk(out_z == e.z, "R1 decision list", 128'(out_z), 128'(e.z));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ncyc++;
        compare();
    endtask

    // Model: finish a row and queue its expected results
    task automatic model_row_end();
        exp_t e;
        int   m1[Q];
        int   m2[Q];
        int   ix[Q];
        int   sx;
        e.m1 = '0; e.m2 = '0; e.dq = '0; e.idx = '0; e.z = '0;
        sx = 0;
        for (int c = 0; c < DC; c++) begin
            sx = sx ^ fz[c];
            e.z[c*P +: P] = P'(fz[c]);
        end
        e.syn = P'(sx);
        for (int a = 0; a < Q; a++) begin
            m1[a] = 1000; m2[a] = 1000; ix[a] = 0;
            for (int c = 0; c < DC; c++) begin
                if (fd[c][a] < m1[a]) begin
                    m2[a] = m1[a]; m1[a] = fd[c][a]; ix[a] = c;
                end else if (fd[c][a] < m2[a]) begin
                    m2[a] = fd[c][a];
                end
            end
            e.m1[a*W +: W]       = W'(m1[a]);
            e.m2[a*W +: W]       = W'(m2[a]);
            e.idx[a*IDXW +: IDXW] = IDXW'(ix[a]);
        end
        for (int a = 1; a < Q; a++) begin
            int best;
            best = m1[a];
            for (int b = 1; b < Q; b++) begin
                if (b != a) begin
                    int t;
                    t = (m1[b] > m1[b ^ a]) ? m1[b] : m1[b ^ a];
                    if (t < best) best = t;
                end
            end
            e.dq[a*W +: W] = W'(best);
        end
        e.due = ncyc + 2;
        expq.push_back(e);
    endtask

    // Drive one valid column from vals[] and record it in the model
    task automatic drive_col(input bit last);
        int z;
        z = 0;
        for (int a = 0; a < Q; a++) begin
            in_vec[a*W +: W] = W'(vals[a]);
            if (vals[a] < vals[z]) z = a;
        end
        fz[fcol] = z;
        for (int a = 0; a < Q; a++) fd[fcol][a ^ z] = vals[a];
        in_valid = 1'b1;
        in_last  = last;
        fcol++;
        if (last) begin
            model_row_end();
            fcol = 0;
        end
        tick();
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic idle_junk(input int n);
        for (int i = 0; i < n; i++) begin
            for (int a = 0; a < Q; a++) in_vec[a*W +: W] = W'($urandom_range(0, 63));
            in_last = 1'b1;   // R8: flag and data with valid low must be ignored
            tick();
        end
        in_last = 1'b0;
    endtask

    task automatic rand_row(input int gap);
        for (int c = 0; c < DC; c++) begin
            for (int a = 0; a < Q; a++) vals[a] = $urandom_range(0, 63);
            drive_col(c == DC - 1);
            if (gap > 0 && c != DC - 1) idle_junk(gap);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 valid after reset", 128'(out_valid), 128'(0));
        chk(out_m1 == '0 && out_m2 == '0 && out_dq == '0, "R10 tables after reset",
            128'(out_m1), 128'(0));
        chk(out_syn == '0 && out_z == '0 && out_idx == '0, "R10 decisions after reset",
            128'(out_z), 128'(0));

        // R1/R3: all values equal -> symbol 0 and column 0 win every tie
        for (int c = 0; c < DC; c++) begin
            for (int a = 0; a < Q; a++) vals[a] = 20;
            drive_col(c == DC - 1);
        end
        tick(); tick();

        // R1/R4: distinct decisions, duplicated minima across columns
        for (int c = 0; c < DC; c++) begin
            for (int a = 0; a < Q; a++) vals[a] = 30 + ((a * 7 + c) % 16);
            vals[(c * 5 + 3) % Q] = 4;
            vals[(c * 3 + 1) % Q] = 4;
            drive_col(c == DC - 1);
        end
        tick(); tick();

        // R5/R10 extremes: every value saturated high
        for (int c = 0; c < DC; c++) begin
            for (int a = 0; a < Q; a++) vals[a] = 63;
            vals[c] = 0;
            drive_col(c == DC - 1);
        end
        tick();

        // R8: junk between columns with valid low
        rand_row(2);
        rand_row(1);
        tick(); tick();

        // R9: back-to-back rows with no idle cycle
        for (int k = 0; k < 20; k++) rand_row(0);
        tick(); tick(); tick();

        chk(expq.size() == 0, "R7 all rows emitted", 128'(expq.size()), 128'(0));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule